// File: doc/BRIEF.md
# Ping-Pong Waveform Window Buffer

This block models and controls the digital side of one channel of a multi-window waveform recorder. Incoming samples are gathered into fixed-size windows by two alternating capture lanes. While one lane fills with the current window, the other hands its finished window to a circular window store. Each finished window advances a write pointer around the ring.

A trigger carries a lookback distance counted in windows. When the readout engine is idle, a trigger selects a run of consecutive windows that begins that many windows behind the write pointer. These windows are write-protected while they are read. Each selected window passes through a conversion stage of fixed latency that digitises the whole window at once. Its samples are then streamed out one per cycle, each tagged with its window number and sample index. A trigger that arrives while a readout is running is counted and otherwise ignored.

Top module: `ppwb_window_buffer`

## Requirements
- R1: After reset, out_valid, out_last and skip_flag are low, busy is low, drop_cnt is zero, and the write pointer is 0, so the first completed window lands in window 0.
- R2: A sample is accepted on each cycle with smp_valid high. Every 64 accepted samples form one window, and the capture lanes alternate window by window, starting with lane 0.
- R3: A completed window goes to the store at the write pointer one cycle after its last sample. The pointer then advances by exactly one and wraps from 511 to 0.
- R4: A trigger accepted while idle selects a first window equal to (write pointer − trig_lookback) mod 512. The write pointer used is the value it has in the trigger cycle.
- R5: Exactly 4 windows are read per accepted trigger, at consecutive window numbers that wrap from 511 to 0.
- R6: Each selected window is read after a conversion gap of CONV_LAT cycles. Its 64 samples then come out on consecutive cycles with out_idx running 0 to 63, out_win giving the window number, and out_data equal to the sample that was stored.
- R7: out_last is high only on the sample with index 63 of the fourth window of a readout.
- R8: While a readout is active, a completed window whose target is one of the 4 selected windows is not stored, so that slot keeps its old content. The pointer still advances by one, and skip_flag pulses for one cycle.
- R9: Protection ends with the readout. A later window written to a previously selected slot is stored normally, without a skip.
- R10: A trigger that arrives while busy increments drop_cnt, which saturates at its maximum. It leaves the running readout's samples, tags and length unchanged.
- R11: busy rises in the cycle after an accepted trigger and falls once the last sample of the fourth window has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Sample value |
| trig | input | 1 | Readout request |
| trig_lookback | input | log2(NUM_WINDOWS) | Windows to look back from the write pointer |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | SAMPLE_W | Converted sample |
| out_win | output | log2(NUM_WINDOWS) | Window number of the sample |
| out_idx | output | log2(WIN_SAMPLES) | Sample index within the window |
| out_last | output | 1 | Final sample of the readout |
| skip_flag | output | 1 | A completed window was discarded because its slot was protected |
| busy | output | 1 | Readout in progress |
| drop_cnt | output | DROP_W | Saturating count of triggers ignored while busy |

## Verification
The bench first fills more than the whole ring, so the pointer wraps. It then chooses a lookback that makes the first window 510, so the run of four crosses from 511 to 0. A design that wraps wrongly would return the wrong window tags or stale data there. A trigger with a lookback of zero, followed by windows written during the readout, aims the writer straight at the protected slots. A later readout of those slots shows whether their old contents survived and whether the pointer still moved on. A trigger injected in the middle of a readout has to raise the drop count without adding or truncating samples. After protection ends, a write to a formerly protected slot has to go through, which catches a protection that is never released.

// File: rtl/ppwb_pkg.sv
package ppwb_pkg;
   typedef enum logic [1:0] {
      RD_IDLE,
      RD_LOAD,
      RD_CONV,
      RD_STREAM
   } rd_state_t;
endpackage

// File: rtl/ppwb_lane_pair.sv
module ppwb_lane_pair #(
   parameter int SAMPLE_W    = 12,
   parameter int WIN_SAMPLES = 64
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  smp_valid,
   input  logic [SAMPLE_W-1:0]                   smp_data,
   output logic                                  xfer_req,
   output logic [WIN_SAMPLES-1:0][SAMPLE_W-1:0]  xfer_win
);
   localparam int IDX_W = $clog2(WIN_SAMPLES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_SAMPLES - 1);

   logic [IDX_W-1:0] idx_q;
   logic             rec_q;
   logic             xlane_q;
   logic             xfer_q;
   logic [WIN_SAMPLES-1:0][SAMPLE_W-1:0] lane_q [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         rec_q   <= 1'b0;
         xlane_q <= 1'b0;
         xfer_q  <= 1'b0;
      end else begin
         xfer_q <= 1'b0;
         if (smp_valid) begin
            if (idx_q == LAST_IDX) begin
               idx_q   <= '0;
               rec_q   <= ~rec_q;
               xlane_q <= rec_q;
               xfer_q  <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   // capture storage: the recording lane takes the sample, the other lane is held
   always_ff @(posedge clk) begin
      if (smp_valid)
         lane_q[rec_q][idx_q] <= smp_data;
   end

   assign xfer_req = xfer_q;
   assign xfer_win = lane_q[xlane_q];

   // R2
   lane_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && idx_q == LAST_IDX) |=> (rec_q != $past(rec_q)));

   // R3
   xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_q |=> !xfer_q);
endmodule

// File: rtl/ppwb_ring.sv
module ppwb_ring #(
   parameter int SAMPLE_W     = 12,
   parameter int WIN_SAMPLES  = 64,
   parameter int NUM_WINDOWS  = 512,
   parameter int READ_WINDOWS = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  xfer_req,
   input  logic [WIN_SAMPLES-1:0][SAMPLE_W-1:0]  xfer_win,
   input  logic                                  prot_active,
   input  logic [$clog2(NUM_WINDOWS)-1:0]        prot_base,
   input  logic [$clog2(NUM_WINDOWS)-1:0]        rd_addr,
   output logic [WIN_SAMPLES-1:0][SAMPLE_W-1:0]  rd_win,
   output logic [$clog2(NUM_WINDOWS)-1:0]        wr_ptr,
   output logic                                  skip_flag
);
   localparam int PTR_W = $clog2(NUM_WINDOWS);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] prot_off;
   logic             hit_prot;
   logic             skip_q;
   logic [WIN_SAMPLES-1:0][SAMPLE_W-1:0] mem_q [NUM_WINDOWS];

   // distance of the write target past the protected base, modulo the ring
   assign prot_off = ptr_q - prot_base;
   assign hit_prot = prot_active && (prot_off < PTR_W'(READ_WINDOWS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         skip_q <= 1'b0;
      end else begin
         skip_q <= 1'b0;
         if (xfer_req) begin
            ptr_q  <= ptr_q + 1'b1;
            skip_q <= hit_prot;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (xfer_req && !hit_prot)
         mem_q[ptr_q] <= xfer_win;
   end

   assign rd_win    = mem_q[rd_addr];
   assign wr_ptr    = ptr_q;
   assign skip_flag = skip_q;

   // R3
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

   // R3
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_req |=> $stable(ptr_q));

   // R8
   skip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_q |-> ($past(prot_active) && $past(xfer_req)));
endmodule

// File: rtl/ppwb_readout.sv
module ppwb_readout #(
   parameter int SAMPLE_W     = 12,
   parameter int WIN_SAMPLES  = 64,
   parameter int NUM_WINDOWS  = 512,
   parameter int READ_WINDOWS = 4,
   parameter int CONV_LAT     = 3,
   parameter int DROP_W       = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  trig,
   input  logic [$clog2(NUM_WINDOWS)-1:0]        trig_lookback,
   input  logic [$clog2(NUM_WINDOWS)-1:0]        wr_ptr,
   input  logic [WIN_SAMPLES-1:0][SAMPLE_W-1:0]  rd_win,
   output logic [$clog2(NUM_WINDOWS)-1:0]        rd_addr,
   output logic                                  prot_active,
   output logic [$clog2(NUM_WINDOWS)-1:0]        prot_base,
   output logic                                  out_valid,
   output logic [SAMPLE_W-1:0]                   out_data,
   output logic [$clog2(NUM_WINDOWS)-1:0]        out_win,
   output logic [$clog2(WIN_SAMPLES)-1:0]        out_idx,
   output logic                                  out_last,
   output logic                                  busy,
   output logic [DROP_W-1:0]                     drop_cnt
);
   import ppwb_pkg::*;

   localparam int PTR_W = $clog2(NUM_WINDOWS);
   localparam int IDX_W = $clog2(WIN_SAMPLES);
   localparam int RW_W  = (READ_WINDOWS > 1) ? $clog2(READ_WINDOWS) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_SAMPLES - 1);
   localparam logic [RW_W-1:0]  LAST_WIN = RW_W'(READ_WINDOWS - 1);

   rd_state_t            state_q;
   logic [PTR_W-1:0]     base_q;
   logic [PTR_W-1:0]     addr_q;
   logic [RW_W-1:0]      woff_q;
   logic [IDX_W-1:0]     sidx_q;
   logic [DROP_W-1:0]    drop_q;
   logic                 conv_done;
   logic                 ov_q;
   logic                 ol_q;
   logic [SAMPLE_W-1:0]  od_q;
   logic [PTR_W-1:0]     ow_q;
   logic [IDX_W-1:0]     oi_q;
   logic [WIN_SAMPLES-1:0][SAMPLE_W-1:0] buf_q;

   generate
      if (CONV_LAT == 0) begin : g_conv_none
         assign conv_done = 1'b1;
      end else begin : g_conv_wait
         localparam int CW = $clog2(CONV_LAT + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (state_q == RD_CONV) cnt_q <= cnt_q + 1'b1;
            else                         cnt_q <= '0;
         end
         assign conv_done = (cnt_q == CW'(CONV_LAT - 1));
      end
   endgenerate

   // conversion register: the whole window is digitised in one pass
   always_ff @(posedge clk) begin
      if (state_q == RD_LOAD)
         buf_q <= rd_win;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
         base_q  <= '0;
         addr_q  <= '0;
         woff_q  <= '0;
         sidx_q  <= '0;
         drop_q  <= '0;
         ov_q    <= 1'b0;
         ol_q    <= 1'b0;
         od_q    <= '0;
         ow_q    <= '0;
         oi_q    <= '0;
      end else begin
         ov_q <= 1'b0;
         ol_q <= 1'b0;
         if (trig && state_q != RD_IDLE && drop_q != {DROP_W{1'b1}})
            drop_q <= drop_q + 1'b1;
         case (state_q)
            RD_IDLE: begin
               if (trig) begin
                  base_q  <= wr_ptr - trig_lookback;
                  addr_q  <= wr_ptr - trig_lookback;
                  woff_q  <= '0;
                  state_q <= RD_LOAD;
               end
            end
            RD_LOAD: begin
               sidx_q  <= '0;
               state_q <= (CONV_LAT == 0) ? RD_STREAM : RD_CONV;
            end
            RD_CONV: begin
               if (conv_done)
                  state_q <= RD_STREAM;
            end
            RD_STREAM: begin
               ov_q   <= 1'b1;
               od_q   <= buf_q[sidx_q];
               ow_q   <= addr_q;
               oi_q   <= sidx_q;
               ol_q   <= (sidx_q == LAST_IDX) && (woff_q == LAST_WIN);
               sidx_q <= sidx_q + 1'b1;
               if (sidx_q == LAST_IDX) begin
                  if (woff_q == LAST_WIN) begin
                     state_q <= RD_IDLE;
                  end else begin
                     woff_q  <= woff_q + 1'b1;
                     addr_q  <= addr_q + 1'b1;
                     state_q <= RD_LOAD;
                  end
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign rd_addr     = addr_q;
   assign prot_active = (state_q != RD_IDLE);
   assign prot_base   = base_q;
   assign busy        = (state_q != RD_IDLE);
   assign drop_cnt    = drop_q;
   assign out_valid   = ov_q;
   assign out_data    = od_q;
   assign out_win     = ow_q;
   assign out_idx     = oi_q;
   assign out_last    = ol_q;

   // R7
   last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ol_q |-> (ov_q && oi_q == LAST_IDX));

   // R6
   idx_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q && oi_q != LAST_IDX) |=> (ov_q && oi_q == IDX_W'($past(oi_q) + 1'b1)
                                       && ow_q == $past(ow_q)));

   // R10
   drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_q != $past(drop_q)) |-> ($past(trig) && $past(busy)));

   // R11
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(trig));
endmodule

// File: rtl/ppwb_window_buffer.sv
module ppwb_window_buffer #(
   parameter int SAMPLE_W     = 12,
   parameter int WIN_SAMPLES  = 64,
   parameter int NUM_WINDOWS  = 512,
   parameter int READ_WINDOWS = 4,
   parameter int CONV_LAT     = 3,
   parameter int DROP_W       = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            smp_valid,
   input  logic [SAMPLE_W-1:0]             smp_data,
   input  logic                            trig,
   input  logic [$clog2(NUM_WINDOWS)-1:0]  trig_lookback,
   output logic                            out_valid,
   output logic [SAMPLE_W-1:0]             out_data,
   output logic [$clog2(NUM_WINDOWS)-1:0]  out_win,
   output logic [$clog2(WIN_SAMPLES)-1:0]  out_idx,
   output logic                            out_last,
   output logic                            skip_flag,
   output logic                            busy,
   output logic [DROP_W-1:0]               drop_cnt
);
   localparam int PTR_W = $clog2(NUM_WINDOWS);

   generate
      if ((NUM_WINDOWS & (NUM_WINDOWS - 1)) != 0 || NUM_WINDOWS < 2) begin : g_bad_ring
         $error("ring size must be a power of two of at least 2");
      end
      if ((WIN_SAMPLES & (WIN_SAMPLES - 1)) != 0 || WIN_SAMPLES < 2) begin : g_bad_win
         $error("window length must be a power of two of at least 2");
      end
      if (READ_WINDOWS < 1 || READ_WINDOWS >= NUM_WINDOWS) begin : g_bad_read
         $error("read count must lie between 1 and ring size minus 1");
      end
      if (CONV_LAT < 0 || DROP_W < 1) begin : g_bad_misc
         $error("conversion latency and drop counter width out of range");
      end
   endgenerate

   logic                                  xfer_req;
   logic [WIN_SAMPLES-1:0][SAMPLE_W-1:0]  xfer_win;
   logic [WIN_SAMPLES-1:0][SAMPLE_W-1:0]  rd_win;
   logic [PTR_W-1:0]                      rd_addr;
   logic [PTR_W-1:0]                      wr_ptr;
   logic [PTR_W-1:0]                      prot_base;
   logic                                  prot_active;

   ppwb_lane_pair #(
      .SAMPLE_W    (SAMPLE_W),
      .WIN_SAMPLES (WIN_SAMPLES)
   ) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .xfer_req  (xfer_req),
      .xfer_win  (xfer_win)
   );

   ppwb_ring #(
      .SAMPLE_W     (SAMPLE_W),
      .WIN_SAMPLES  (WIN_SAMPLES),
      .NUM_WINDOWS  (NUM_WINDOWS),
      .READ_WINDOWS (READ_WINDOWS)
   ) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .xfer_req    (xfer_req),
      .xfer_win    (xfer_win),
      .prot_active (prot_active),
      .prot_base   (prot_base),
      .rd_addr     (rd_addr),
      .rd_win      (rd_win),
      .wr_ptr      (wr_ptr),
      .skip_flag   (skip_flag)
   );

   ppwb_readout #(
      .SAMPLE_W     (SAMPLE_W),
      .WIN_SAMPLES  (WIN_SAMPLES),
      .NUM_WINDOWS  (NUM_WINDOWS),
      .READ_WINDOWS (READ_WINDOWS),
      .CONV_LAT     (CONV_LAT),
      .DROP_W       (DROP_W)
   ) u_readout (
      .clk           (clk),
      .rst_n         (rst_n),
      .trig          (trig),
      .trig_lookback (trig_lookback),
      .wr_ptr        (wr_ptr),
      .rd_win        (rd_win),
      .rd_addr       (rd_addr),
      .prot_active   (prot_active),
      .prot_base     (prot_base),
      .out_valid     (out_valid),
      .out_data      (out_data),
      .out_win       (out_win),
      .out_idx       (out_idx),
      .out_last      (out_last),
      .busy          (busy),
      .drop_cnt      (drop_cnt)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !skip_flag && !busy));
endmodule

// File: tb/tb_ppwb_window_buffer.sv
module tb_ppwb_window_buffer;
   localparam int NW = 512;
   localparam int WS = 64;
   localparam int RN = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic        trig = 1'b0;
   logic [8:0]  trig_lookback = '0;
   logic        out_valid;
   logic [11:0] out_data;
   logic [8:0]  out_win;
   logic [5:0]  out_idx;
   logic        out_last;
   logic        skip_flag;
   logic        busy;
   logic [7:0]  drop_cnt;

   always #4 clk = ~clk;

   ppwb_window_buffer dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .smp_valid     (smp_valid),
      .smp_data      (smp_data),
      .trig          (trig),
      .trig_lookback (trig_lookback),
      .out_valid     (out_valid),
      .out_data      (out_data),
      .out_win       (out_win),
      .out_idx       (out_idx),
      .out_last      (out_last),
      .skip_flag     (skip_flag),
      .busy          (busy),
      .drop_cnt      (drop_cnt)
   );

   typedef struct packed {
      logic [11:0] d;
      logic [8:0]  w;
      logic [5:0]  i;
      logic        l;
   } item_t;

   item_t exp_q[$];
   int    slot_g[NW];
   int    mptr = 0;
   int    gnext = 0;
   bit    mprot = 1'b0;
   int    mbase = 0;
   int    skip_exp = 0;
   int    skip_seen = 0;
   int    vectors = 0;
   int    errors = 0;
   bit    done = 1'b0;

   function automatic logic [11:0] fsamp(int g, int i);
      return 12'((g * 37 + i * 5 + 11) & 4095);
   endfunction

   function automatic void chk(bit ok, string req, string what, int act, int expv);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endfunction

   // reference store: a slot is skipped while it lies in the protected run (R8)
   function automatic void model_write(int g);
      if (mprot && (((mptr - mbase) % NW + NW) % NW) < RN) skip_exp++;
      else slot_g[mptr] = g;
      mptr = (mptr + 1) % NW;
   endfunction

   // monitor: pops expected items as the design streams them
   always @(negedge clk) begin : mon
      item_t e;
      if (rst_n && !done) begin
         if (skip_flag) skip_seen++;
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", "sample with no pending readout, win", int'(out_win), -1);
            end else begin
               e = exp_q.pop_front();
               // R4 R5 R6: window tag, index and stored value
               chk(out_win == e.w, "R4 R5", "window tag", int'(out_win), int'(e.w));
               chk(out_idx == e.i && out_data == e.d, "R6", "index*4096+data",
                   int'(out_idx) * 4096 + int'(out_data), int'(e.i) * 4096 + int'(e.d));
               // R7
               chk(out_last == e.l, "R7", "last flag", int'(out_last), int'(e.l));
            end
         end
      end
   end

   // R2 R3: drives whole windows back to back
   task automatic drive_windows(int n);
      for (int k = 0; k < n; k++) begin
         for (int i = 0; i < WS; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = fsamp(gnext, i);
         end
         model_write(gnext);
         gnext++;
      end
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic fire(int lb);
      int b;
      b = ((mptr - lb) % NW + NW) % NW;
      for (int w = 0; w < RN; w++) begin
         int s;
         s = (b + w) % NW;
         for (int i = 0; i < WS; i++)
            exp_q.push_back('{d: fsamp(slot_g[s], i), w: 9'(s), i: 6'(i),
                              l: (w == RN - 1 && i == WS - 1)});
      end
      mprot = 1'b1;
      mbase = b;
      @(negedge clk);
      trig = 1'b1;
      trig_lookback = 9'(lb);
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic wait_done();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      mprot = 1'b0;
   endtask

   initial begin
      for (int s = 0; s < NW; s++) slot_g[s] = -1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs after reset
      chk(!out_valid, "R1", "out_valid", int'(out_valid), 0);
      chk(!out_last, "R1", "out_last", int'(out_last), 0);
      chk(!skip_flag, "R1", "skip_flag", int'(skip_flag), 0);
      chk(!busy, "R1", "busy", int'(busy), 0);
      chk(drop_cnt == 0, "R1", "drop_cnt", int'(drop_cnt), 0);

      // R1 R2: first windows start at slot 0
      drive_windows(6);
      fire(6);
      wait_done();

      // R3: fill past the ring end so the pointer wraps
      drive_windows(514);

      // R5: run crosses 511 -> 0
      fire(10);
      wait_done();

      // R10 R11: trigger mid-readout is dropped
      fire(100);
      chk(busy, "R11", "busy after trigger", int'(busy), 1);
      repeat (100) @(negedge clk);
      trig = 1'b1;
      trig_lookback = 9'd3;
      @(negedge clk);
      trig = 1'b0;
      wait_done();
      chk(drop_cnt == 1, "R10", "drop_cnt", int'(drop_cnt), 1);
      chk(!busy, "R11", "busy after readout", int'(busy), 0);

      // R8: writer aims at the protected run
      fire(0);
      drive_windows(4);
      wait_done();
      chk(skip_seen == skip_exp, "R8", "skip pulses", skip_seen, skip_exp);
      chk(skip_exp == 4, "R8", "expected skips", skip_exp, 4);
      // R8: skipped slots keep old content, pointer moved on by 4
      fire(4);
      wait_done();

      // R9: protection is released after the readout
      fire(0);
      wait_done();
      drive_windows(1);
      fire(1);
      wait_done();
      chk(skip_seen == 4, "R9", "no skip after release", skip_seen, 4);
      chk(drop_cnt == 1, "R10", "drop_cnt unchanged", int'(drop_cnt), 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "R1", "watchdog expired, pending items", exp_q.size(), 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule